// File: doc/BRIEF.md
# External Pin Interrupt Controller

This block turns up to eight external, already-synchronous pin inputs into interrupt requests. Each pin has a programmable trigger condition and a four-bit priority field. Each pin also has a pending flag and a mask flag. A pin raises its own interrupt output when it is pending, unmasked, has a nonzero priority and the controller is in individual-pin mode. A single combined output is the OR of all pin outputs.

Software reaches the block through a plain 32-bit register port: a word address, a write strobe, write data and combinational read data. The register map, by word address, is:

- 0: trigger-select register.
- 1: priority register.
- 2: pending register.
- 3: write-only mask-set register.
- 4: write-only mask-clear register.
- 5: control register.

In every register that has one bit per pin, pin 0 sits at the most significant bit of that register's width. Trigger and priority fields are packed from the top of the word, with pin 0 first.

Top module: `extpin_irq_ctrl`

## Requirements
- R1: After reset, every register address reads zero, all pins are masked, all priority and trigger fields are zero, no pin is pending, and both outputs are low.
- R2: In the pending register, pin n occupies bit (BIT_W-1-n), with BIT_W = 8 by default. Reads of that register return the pending flags in that order.
- R3: Pin n's trigger field is SENSE_W bits wide (4 by default, 2 as a build option) and starts at bit 32-(n+1)*SENSE_W of the trigger-select register. The register reads back as written for every implemented pin.
- R4: The edge trigger codes are 0 for falling, 1 for rising and 4 for either edge. An edge code sets a pin's pending flag only when the pin value differs from its value one cycle earlier in the coded direction. A pending flag never rises without such an event.
- R5: Code 2 (low level) and code 3 (high level) set the pending flag on every cycle the level is present, so the flag comes back after a clear while the level persists.
- R6: A write to the pending register clears each pin whose bit is written 0 and leaves pins written 1 unchanged. A trigger event in the same cycle as a clear wins and leaves the flag set.
- R7: Writing 1 to a pin's bit of the mask-set register masks that pin. Writing 1 to its bit of the mask-clear register unmasks it. Zero bits change nothing, and both addresses read zero.
- R8: A priority field of zero blocks that pin's output. Any nonzero field lets it through. Pin n's field starts at bit 28-4n.
- R9: Pin output n is high exactly when pin n is pending, unmasked, has nonzero priority and the mode bit is set. The combined output is the OR of the pin outputs.
- R10: Bit 23 of the control register is a readable mode bit, reset to 0. While it is 0, every output is held low, but pending flags still collect events.
- R11: Trigger codes 5 to 15 never set a pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bus_addr_i | input | 3 | Register word address |
| bus_we_i | input | 1 | Write strobe for the addressed register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data of the addressed register (combinational) |
| pin_i | input | NPIN | Pin levels, bit n is pin n |
| irq_o | output | NPIN | Per-pin interrupt requests, bit n is pin n |
| irq_any_o | output | 1 | OR of all per-pin requests |

## Verification
Assertions watch every cycle for the following:

- A pending flag may appear only after a trigger event, and every event must leave its flag set.
- A pending-register write must drop each pin written 0 that had no event in that cycle.
- Mask-set and mask-clear writes must take effect on the next cycle, and the mask must stay unchanged otherwise.
- An output must never be high without a pending flag, and must never be high with priority zero or with the mode bit clear.

The bench scenarios cover the rest:

- The bit and field positions seen through reads.
- The exact conditions under which each trigger code fires.
- Level re-assertion after a clear.
- Codes that must stay inert.
- Interleaved random traffic checked against an independent model.

// File: rtl/extpin_irq_pkg.sv
package extpin_irq_pkg;

  localparam int ADDR_W   = 3;
  localparam int WORD_W   = 32;
  localparam int PRIO_W   = 4;
  localparam int MODE_BIT = 23;

  typedef enum logic [ADDR_W-1:0] {
    A_SENSE = 3'd0,
    A_PRIO  = 3'd1,
    A_SRC   = 3'd2,
    A_MSET  = 3'd3,
    A_MCLR  = 3'd4,
    A_CTRL  = 3'd5
  } reg_sel_e;

  typedef enum logic [3:0] {
    TRG_FALL = 4'd0,
    TRG_RISE = 4'd1,
    TRG_LOW  = 4'd2,
    TRG_HIGH = 4'd3,
    TRG_BOTH = 4'd4
  } trig_e;

  // lowest bit of pin's packed field, fields filled from the top of the word
  function automatic int field_lsb(int pin, int fw);
    return WORD_W - (pin + 1) * fw;
  endfunction

  // bit of pin in a one-bit-per-pin register of width bw
  function automatic int bit_pos(int pin, int bw);
    return bw - 1 - pin;
  endfunction

  // trigger decision for one pin given current and previous sample
  function automatic logic trig_hit(logic [3:0] code, logic cur, logic prev);
    case (code)
      TRG_FALL: return prev & ~cur;
      TRG_RISE: return ~prev & cur;
      TRG_LOW:  return ~cur;
      TRG_HIGH: return cur;
      TRG_BOTH: return prev ^ cur;
      default:  return 1'b0;
    endcase
  endfunction

  function automatic logic prio_open(logic [PRIO_W-1:0] p);
    return |p;
  endfunction

endpackage

// File: rtl/extpin_pin_detect.sv
module extpin_pin_detect
  import extpin_irq_pkg::*;
#(
  parameter int SENSE_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pin_i,
  input  logic [SENSE_W-1:0] code_i,
  output logic               evt_o
);

  logic       pin_q;
  logic [3:0] code4;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) pin_q <= 1'b0;
    else         pin_q <= pin_i;
  end

  always_comb begin
    code4 = '0;
    code4[SENSE_W-1:0] = code_i;
  end

  assign evt_o = trig_hit(code4, pin_i, pin_q);

endmodule

// File: rtl/extpin_regs.sv
module extpin_regs
  import extpin_irq_pkg::*;
#(
  parameter int NPIN    = 8,
  parameter int SENSE_W = 4,
  parameter int BIT_W   = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic                           we_i,
  input  logic [WORD_W-1:0]              wdata_i,
  output logic [WORD_W-1:0]              rdata_o,
  input  logic [NPIN-1:0]                ev_i,
  output logic [NPIN-1:0][SENSE_W-1:0]   sense_o,
  output logic [NPIN-1:0][PRIO_W-1:0]    prio_o,
  output logic [NPIN-1:0]                pend_o,
  output logic [NPIN-1:0]                mask_o,
  output logic                           mode_o
);

  reg_sel_e sel;
  logic hit_sense, hit_prio, hit_src, hit_mset, hit_mclr, hit_ctrl;

  logic [NPIN-1:0][SENSE_W-1:0] sense_q, wr_sense;
  logic [NPIN-1:0][PRIO_W-1:0]  prio_q, wr_prio;
  logic [NPIN-1:0]              pend_q, mask_q, wr_bits, clr_vec;
  logic                         mode_q;
  logic [WORD_W-1:0]            rd;

  assign sel       = reg_sel_e'(addr_i);
  assign hit_sense = we_i && (sel == A_SENSE);
  assign hit_prio  = we_i && (sel == A_PRIO);
  assign hit_src   = we_i && (sel == A_SRC);
  assign hit_mset  = we_i && (sel == A_MSET);
  assign hit_mclr  = we_i && (sel == A_MCLR);
  assign hit_ctrl  = we_i && (sel == A_CTRL);

  for (genvar p = 0; p < NPIN; p++) begin : g_field
    localparam int SL = field_lsb(p, SENSE_W);
    localparam int PL = field_lsb(p, PRIO_W);
    localparam int BP = bit_pos(p, BIT_W);
    assign wr_sense[p] = wdata_i[SL +: SENSE_W];
    assign wr_prio[p]  = wdata_i[PL +: PRIO_W];
    assign wr_bits[p]  = wdata_i[BP];
  end

  // pins written 0 in a pending-register write
  assign clr_vec = hit_src ? ~wr_bits : '0;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      sense_q <= '0;
      prio_q  <= '0;
      pend_q  <= '0;
      mask_q  <= '1;
      mode_q  <= 1'b0;
    end else begin
      if (hit_sense) sense_q <= wr_sense;
      if (hit_prio)  prio_q  <= wr_prio;
      if (hit_ctrl)  mode_q  <= wdata_i[MODE_BIT];
      // a fresh event outranks a clear landing in the same cycle
      pend_q <= ev_i | (pend_q & ~clr_vec);
      if (hit_mset)      mask_q <= mask_q | wr_bits;
      else if (hit_mclr) mask_q <= mask_q & ~wr_bits;
    end
  end

  always_comb begin
    rd = '0;
    case (sel)
      A_SENSE: for (int p = 0; p < NPIN; p++) rd[field_lsb(p, SENSE_W) +: SENSE_W] = sense_q[p];
      A_PRIO:  for (int p = 0; p < NPIN; p++) rd[field_lsb(p, PRIO_W) +: PRIO_W] = prio_q[p];
      A_SRC:   for (int p = 0; p < NPIN; p++) rd[bit_pos(p, BIT_W)] = pend_q[p];
      A_CTRL:  rd[MODE_BIT] = mode_q;
      default: rd = '0;
    endcase
  end

  assign rdata_o = rd;
  assign sense_o = sense_q;
  assign prio_o  = prio_q;
  assign pend_o  = pend_q;
  assign mask_o  = mask_q;
  assign mode_o  = mode_q;

  AST_EVENT_SETS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i != '0) |=> ((pend_q & $past(ev_i)) == $past(ev_i))); // R6
  AST_PEND_NEEDS_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_q & ~$past(pend_q) & ~$past(ev_i)) == '0)); // R4
  AST_CLEAR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_src |=> ((pend_q & $past(clr_vec) & ~$past(ev_i)) == '0)); // R6
  AST_MASK_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_mset |=> ((mask_q & $past(wr_bits)) == $past(wr_bits))); // R7
  AST_MASK_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_mclr |=> ((mask_q & $past(wr_bits)) == '0)); // R7
  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_mset || hit_mclr) |=> $stable(mask_q)); // R7

endmodule

// File: rtl/extpin_out_gate.sv
module extpin_out_gate
  import extpin_irq_pkg::*;
#(
  parameter int NPIN = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NPIN-1:0]             pend_i,
  input  logic [NPIN-1:0]             mask_i,
  input  logic [NPIN-1:0][PRIO_W-1:0] prio_i,
  input  logic                        mode_i,
  output logic [NPIN-1:0]             irq_o,
  output logic                        irq_any_o
);

  logic [NPIN-1:0] gate_open;

  for (genvar p = 0; p < NPIN; p++) begin : g_gate
    assign gate_open[p] = prio_open(prio_i[p]) & ~mask_i[p];
    assign irq_o[p]     = pend_i[p] & gate_open[p] & mode_i;

    AST_PRIO_ZERO_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (prio_i[p] == '0) |-> !irq_o[p]); // R8
  end

  assign irq_any_o = |irq_o;

endmodule

// File: rtl/extpin_irq_ctrl.sv
module extpin_irq_ctrl
  import extpin_irq_pkg::*;
#(
  parameter int NPIN    = 8,
  parameter int SENSE_W = 4,
  parameter int BIT_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        bus_addr_i,
  input  logic              bus_we_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic [NPIN-1:0]   pin_i,
  output logic [NPIN-1:0]   irq_o,
  output logic              irq_any_o
);

  logic [NPIN-1:0]              trig_evt;
  logic [NPIN-1:0][SENSE_W-1:0] sense;
  logic [NPIN-1:0][PRIO_W-1:0]  prio;
  logic [NPIN-1:0]              pend, mask;
  logic                         mode;

  for (genvar p = 0; p < NPIN; p++) begin : g_det
    extpin_pin_detect #(.SENSE_W(SENSE_W)) u_det (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .pin_i (pin_i[p]),
      .code_i(sense[p]),
      .evt_o (trig_evt[p])
    );
  end

  extpin_regs #(.NPIN(NPIN), .SENSE_W(SENSE_W), .BIT_W(BIT_W)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (bus_addr_i),
    .we_i   (bus_we_i),
    .wdata_i(bus_wdata_i),
    .rdata_o(bus_rdata_o),
    .ev_i   (trig_evt),
    .sense_o(sense),
    .prio_o (prio),
    .pend_o (pend),
    .mask_o (mask),
    .mode_o (mode)
  );

  extpin_out_gate #(.NPIN(NPIN)) u_gate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pend_i   (pend),
    .mask_i   (mask),
    .prio_i   (prio),
    .mode_i   (mode),
    .irq_o    (irq_o),
    .irq_any_o(irq_any_o)
  );

  AST_OUT_NEEDS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq_o & ~pend) == '0)); // R9
  AST_OUT_NEEDS_UNMASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq_o & mask) == '0)); // R9
  AST_MODE_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode |-> (irq_o == '0 && !irq_any_o)); // R10

endmodule

// File: tb/extpin_irq_ctrl_tb_top.sv
module extpin_irq_ctrl_tb_top;

  localparam int NP = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic [2:0]  addr;
  logic        we;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [NP-1:0] pins;
  logic [NP-1:0] irq;
  logic        irq_any;

  int checks = 0;
  int fails  = 0;

  logic [3:0]    m_sense [NP];
  logic [3:0]    m_prio  [NP];
  logic [NP-1:0] m_pend, m_mask, m_prev;
  logic          m_mode;
  logic [31:0]   last_rd;
  logic [NP-1:0] last_irq;

  extpin_irq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pin_i(pins),
    .irq_o(irq), .irq_any_o(irq_any)
  );

  function automatic logic m_hit(logic [3:0] c, logic now, logic was);
    if (c == 4'd3) return now;
    if (c == 4'd2) return !now;
    if (c == 4'd4) return now != was;
    if (c == 4'd1) return now && !was;
    if (c == 4'd0) return was && !now;
    return 1'b0;
  endfunction

  function automatic logic [31:0] m_read(logic [2:0] a);
    logic [31:0] w = '0;
    for (int p = 0; p < NP; p++) begin
      if (a == 3'd0) w[28-4*p +: 4] = m_sense[p];
      if (a == 3'd1) w[28-4*p +: 4] = m_prio[p];
      if (a == 3'd2) w[7-p] = m_pend[p];
    end
    if (a == 3'd5) w[23] = m_mode;
    return w;
  endfunction

  function automatic logic [NP-1:0] m_irq();
    logic [NP-1:0] v;
    for (int p = 0; p < NP; p++)
      v[p] = m_pend[p] && !m_mask[p] && (m_prio[p] != 0) && m_mode;
    return v;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, logic [2:0] a, logic w, logic [31:0] d, logic [NP-1:0] p);
    logic [NP-1:0] ev, clr;
    @(negedge clk);
    addr = a; we = w; wdata = d; pins = p;
    #1;
    last_irq = irq;
    chk({tag, " R9 irq"}, 32'(irq), 32'(m_irq()));
    chk({tag, " R9 any"}, 32'(irq_any), 32'(|m_irq()));
    if (!w) begin
      last_rd = rdata;
      chk({tag, " read"}, rdata, m_read(a));
    end
    for (int k = 0; k < NP; k++) ev[k] = m_hit(m_sense[k], p[k], m_prev[k]);
    clr = '0;
    if (w && a == 3'd2) for (int k = 0; k < NP; k++) clr[k] = !d[7-k];
    @(posedge clk);
    m_pend = ev | (m_pend & ~clr);
    m_prev = p;
    if (w) begin
      for (int k = 0; k < NP; k++) begin
        if (a == 3'd0) m_sense[k] = d[28-4*k +: 4];
        if (a == 3'd1) m_prio[k]  = d[28-4*k +: 4];
        if (a == 3'd3 && d[7-k]) m_mask[k] = 1'b1;
        if (a == 3'd4 && d[7-k]) m_mask[k] = 1'b0;
      end
      if (a == 3'd5) m_mode = d[23];
    end
  endtask

  task automatic look(string tag, logic [NP-1:0] p);
    step(tag, 3'd2, 1'b0, 32'h0, p);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; addr = '0; we = 1'b0; wdata = '0; pins = '0;
    for (int p = 0; p < NP; p++) begin m_sense[p] = '0; m_prio[p] = '0; end
    m_pend = '0; m_mask = '1; m_prev = '0; m_mode = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: every address reads zero after reset
    for (int a = 0; a < 8; a++) begin
      step("R1 reset read", 3'(a), 1'b0, 32'h0, 8'h00);
      chk("R1 reset zero", last_rd, 32'h0);
    end
    chk("R1 outputs low", 32'(last_irq), 32'h0);

    // R10: mode bit at 23
    step("R10 wr", 3'd5, 1'b1, 32'h0080_0000, 8'h00);
    step("R10 rd", 3'd5, 1'b0, 32'h0, 8'h00);
    chk("R10 mode readback", last_rd, 32'h0080_0000);

    // R3: field positions, pin0 falling, pin1 rising, pin2 low, pin3 high, pin4 both
    step("R3 wr", 3'd0, 1'b1, 32'h0123_4000, 8'h00);
    step("R3 rd", 3'd0, 1'b0, 32'h0, 8'h00);
    chk("R3 sense readback", last_rd, 32'h0123_4000);
    step("R8 prio", 3'd1, 1'b1, 32'hFFFF_FFFF, 8'h00);
    step("R7 unmask", 3'd4, 1'b1, 32'h0000_00FF, 8'h00);

    // R4/R2: rising edge on pin1, low level on pin2
    step("R6 clr", 3'd2, 1'b1, 32'h0, 8'h00);
    look("R4 edge", 8'h02);
    look("R4 after", 8'h02);
    chk("R4 rising sets pin1", 32'(last_rd[6]), 32'h1);
    chk("R2 pin order", last_rd, 32'h0000_0060);

    // R5: level reasserts after clear
    step("R5 clr", 3'd2, 1'b1, 32'h0, 8'h02);
    look("R5 after", 8'h02);
    chk("R5 level reasserts", last_rd, 32'h0000_0020);

    // R6: edge in the clear cycle wins, zero bits clear
    look("R6 drop", 8'h00);
    step("R6 clr+edge", 3'd2, 1'b1, 32'h0, 8'h02);
    look("R6 after", 8'h02);
    chk("R6 new event wins", last_rd, 32'h0000_0060);
    step("R6 partial", 3'd2, 1'b1, 32'h0000_00BF, 8'h02);
    look("R6 after2", 8'h02);
    chk("R6 zero clears one", last_rd, 32'h0000_0020);

    // R11: code 0xA on pin5 stays inert
    step("R11 wr", 3'd0, 1'b1, 32'h0000_0A00, 8'h00);
    step("R11 clr", 3'd2, 1'b1, 32'h0, 8'h00);
    for (int i = 0; i < 6; i++) look("R11 toggle", (i % 2) ? 8'h00 : 8'h20);
    look("R11 after", 8'h00);
    chk("R11 invalid code inert", 32'(last_rd[2]), 32'h0);

    // R8: priority zero blocks
    step("R8 sense0", 3'd0, 1'b1, 32'h0, 8'h00);
    step("R8 prio0", 3'd1, 1'b1, 32'h0, 8'h01);
    look("R8 fall", 8'h00);
    look("R8 obs", 8'h00);
    chk("R8 prio zero blocks", 32'(last_irq), 32'h0);
    step("R8 prio1", 3'd1, 1'b1, 32'h1000_0000, 8'h00);
    look("R8 obs2", 8'h00);
    chk("R8 nonzero opens", 32'(last_irq), 32'h1);

    // R7: zero bits no effect, write-only reads zero
    step("R7 mset0", 3'd3, 1'b1, 32'h0, 8'h00);
    step("R7 rd", 3'd3, 1'b0, 32'h0, 8'h00);
    chk("R7 mset reads zero", last_rd, 32'h0);
    chk("R7 zero write ignored", 32'(last_irq), 32'h1);
    step("R7 mset", 3'd3, 1'b1, 32'h80, 8'h00);
    look("R7 obs", 8'h00);
    chk("R7 masked", 32'(last_irq), 32'h0);
    step("R7 mclr", 3'd4, 1'b1, 32'h80, 8'h00);
    look("R7 obs2", 8'h00);
    chk("R7 unmasked", 32'(last_irq), 32'h1);

    // R10: mode off silences outputs
    step("R10 off", 3'd5, 1'b1, 32'h0, 8'h00);
    look("R10 obs", 8'h00);
    chk("R10 mode off quiet", 32'(last_irq), 32'h0);
    step("R10 on", 3'd5, 1'b1, 32'h0080_0000, 8'h00);

    // random traffic against the model (R3..R9)
    begin
      int unsigned seed = 32'd12345;
      void'($urandom(seed));
      for (int i = 0; i < 4000; i++) begin
        logic [2:0]  ra;
        logic        rw;
        logic [31:0] rdw;
        ra  = 3'($urandom_range(0, 7));
        rw  = ($urandom_range(0, 9) < 3);
        rdw = $urandom();
        if (ra == 3'd5 && ($urandom_range(0, 3) != 0)) rdw[23] = 1'b1;
        step("R9 random", ra, rw, rdw, 8'($urandom()));
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule